// File: doc/BRIEF.md
# Token stream downsampler by N

This block thins a valid/ready token stream. Of every group of N input tokens it forwards only the first, unchanged, and drops the remaining N-1. It is built as a two-state action scheduler. In the copy state, a pass action moves one token into a registered output. In the discard state, a skip action drops tokens and advances a group counter. Also in the discard state, a guarded done action takes no token. It fires once the counter reaches N, resets the counter to 1 and returns to copy.

The scheduler fires exactly one action per clock. When the counter has reached N, done wins over skip even if an input token is waiting, so every group costs one extra, token-free cycle. The output register holds its token until the consumer takes it. A pass waits for room in that register, but skips do not.

Top module: `token_decimator`

## Requirements
- R1: After reset the output is empty (`out_valid` low), the block is in the copy state and `in_ready` is high.
- R2: The first token of each group of KEEP_EVERY accepted tokens appears on `out_data` unchanged, in input order.
- R3: The other KEEP_EVERY-1 tokens of each group are consumed and produce no output token.
- R4: After the last token of a group is consumed, the block spends exactly one cycle with `in_ready` low (the token-free done step), even while `in_valid` is high. The counter then restarts at 1 and never leaves the range 1..KEEP_EVERY.
- R5: In the copy state, with the output register full and `out_ready` low, `in_ready` is low and no token is consumed. Drops in the discard state still proceed.
- R6: With KEEP_EVERY = 1 every token is forwarded, and `in_ready` is low on every second cycle of a continuous stream.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Block consumes the input token this cycle |
| in_data | input | DATA_W | Input token value |
| out_valid | output | 1 | Output register holds a token |
| out_ready | input | 1 | Consumer takes the output token this cycle |
| out_data | output | DATA_W | Output token value |

## Verification
Two actions can be eligible in the same cycle. When the counter reaches N while an input token is already waiting, both done and skip could fire. The bench provokes this by holding `in_valid` high through whole groups, and judges it by the number of cycles with `in_ready` low and by which token is forwarded next. A pass can also coincide with the consumer draining the output register. The bench provokes this with `out_ready` held high and judges it by the scoreboard order, and by checking that no token is lost or duplicated.

// File: rtl/token_decimator.sv
module token_decimator #(
  parameter int DATA_W     = 16,
  parameter int KEEP_EVERY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int CW = $clog2(KEEP_EVERY + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(KEEP_EVERY);

  typedef enum logic { S_COPY, S_DISCARD } state_t;

  state_t        state;
  logic [CW-1:0] cnt;

  logic room, group_end, fire_pass, fire_skip, fire_done;

  assign room      = !out_valid || out_ready;
  assign group_end = (cnt == LAST);
  assign fire_done = (state == S_DISCARD) && group_end;
  assign fire_pass = (state == S_COPY) && in_valid && room;
  assign fire_skip = (state == S_DISCARD) && !group_end && in_valid;
  assign in_ready  = (state == S_COPY) ? room : !group_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_COPY;
      cnt       <= CW'(1);
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (fire_pass) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        state     <= S_DISCARD;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (fire_done) begin
        cnt   <= CW'(1);
        state <= S_COPY;
      end else if (fire_skip) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // A group size of zero has no meaning
  initial begin
    p_group_size_legal: assert (KEEP_EVERY >= 1)
      else $error("KEEP_EVERY must be at least 1");
  end

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= CW'(1) && cnt <= LAST);

  p_done_blocks_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DISCARD && cnt == LAST) |-> !in_ready);

  p_done_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DISCARD && cnt == LAST) |=> (state == S_COPY && cnt == CW'(1)));

  p_pass_forwards_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COPY && in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  p_full_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COPY && out_valid && !out_ready) |-> !in_ready);

  p_hold_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/tb_token_decimator.sv
module tb_token_decimator;
  localparam int W = 16;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic in_valid = 0, out_ready = 1;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;

  logic in_valid1 = 0;
  logic [W-1:0] in_data1 = '0;
  logic in_ready1, out_valid1;
  logic [W-1:0] out_data1;

  token_decimator #(.DATA_W(W), .KEEP_EVERY(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  token_decimator #(.DATA_W(W), .KEEP_EVERY(1)) dut_one (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid1), .in_ready(in_ready1),
    .in_data(in_data1), .out_valid(out_valid1), .out_ready(1'b1), .out_data(out_data1));

  int checks = 0, failures = 0;
  int idx = 0, stalls = 0, one_seen = 0;
  logic [W-1:0] one_exp = '0;
  logic [W-1:0] q[$];
  logic prev_hold = 0;
  logic [W-1:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic send(input logic [W-1:0] d);
    in_valid = 1; in_data = d;
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    if (idx % N == 0) q.push_back(d);
    idx++;
    @(negedge clk);
  endtask

  // scoreboard monitor for the main instance
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_hold) chk(out_valid && out_data == prev_data, "R7 held output", out_data, prev_data);
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(0, "R3 unexpected output", out_data, -1);
        else begin
          logic [W-1:0] e;
          e = q.pop_front();
          chk(out_data == e, "R2 kept token", out_data, e);
        end
      end
      if (out_valid1) begin
        chk(out_data1 == one_exp, "R6 N=1 token", out_data1, one_exp);
        one_exp++;
        one_seen++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    @(negedge clk);

    // continuous stream: done must beat skip
    stalls = 0;
    for (int k = 0; k < 16; k++) send(W'(100 + k));
    in_valid = 0;
    chk(stalls == 3, "R4 done cycles under continuous valid", stalls, 3);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2 R3 all kept tokens out", q.size(), 0);

    // gapped stream
    for (int k = 0; k < 8; k++) begin
      send(W'(300 + 7 * k));
      in_valid = 0;
      repeat (k % 3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3 gapped stream drained", q.size(), 0);

    // backpressure: output full, copy state must stall
    out_ready = 0;
    for (int k = 0; k < N; k++) send(W'(500 + k));
    in_valid = 1; in_data = W'(600);
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 0, "R5 copy stalls on full output", in_ready, 0);
    chk(out_valid == 1, "R5 output still held", out_valid, 1);
    chk(out_data == W'(500), "R5 held value", out_data, 500);
    @(negedge clk);
    out_ready = 1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    q.push_back(W'(600)); idx++;
    @(negedge clk);
    in_valid = 0;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R5 stream resumes in order", q.size(), 0);

    // N = 1 instance: alternate accept and done
    stalls = 0;
    in_valid1 = 1; in_data1 = '0;
    for (int it = 0; it < 12; it++) begin
      #1;
      if (in_ready1) begin
        @(posedge clk); #1;
        in_data1 = in_data1 + 1;
        @(negedge clk);
      end else begin
        stalls++;
        @(negedge clk);
      end
    end
    in_valid1 = 0;
    repeat (3) @(negedge clk);
    chk(stalls == 6, "R6 every second cycle is done", stalls, 6);
    chk(one_seen == 6, "R6 all tokens forwarded", one_seen, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule